// File: doc/BRIEF.md
# Fracturable SIMD Vector Lane ALU

This block is the arithmetic unit of a single vector lane. Its 32-bit datapath is one word, or it is split into two halfwords or four bytes. A size code that arrives with each operation selects the split. Every sub-element is computed independently: no carry, shifted bit or compare result passes from one element into its neighbour. The result is packed back into a 32-bit word in the same element positions.

One operation is presented per cycle, together with a valid strobe. The result and an illegal-operation flag are registered and appear one clock later with a matching valid. The operand `op_b` can carry a scalar that has been broadcast to every element, so the same hardware covers vector-vector and vector-scalar forms.

Top module: `simd_vec_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result` and `illegal_op` are all zero.
- R2: `out_valid` equals the previous cycle's `in_valid`. `result` and `illegal_op` load only on a cycle with `in_valid` high and otherwise hold their values.
- R3: Opcode 0 (add) and opcode 1 (subtract, `op_a - op_b`) work modulo 2^W in each element of width W. A carry or borrow never enters the next element.
- R4: Opcodes 2, 3 and 4 (AND, OR, XOR) are bitwise over all 32 bits for every legal size code.
- R5: Opcode 5 (shift left) and opcode 6 (shift right) are logical with zero fill. Each element of `op_a` shifts by the low log2(W) bits of the matching element of `op_b`, so the amount is taken modulo W. Bits that leave an element are discarded.
- R6: Opcode 7 (minimum) and opcode 8 (maximum) compare each element pair as two's complement when `is_signed` is 1 and as unsigned when it is 0.
- R7: Opcode 9 (multiply-low) returns the low W bits of each element product. The result does not depend on `is_signed`.
- R8: Size code 0 selects bytes (W=8), 1 selects halfwords (W=16) and 2 selects a word (W=32). Size code 3 and opcodes 10 to 15 are illegal: they produce a zero result and `illegal_op` high. A legal operation gives `illegal_op` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode (0 add ... 9 multiply-low) |
| esize | input | 2 | Element size code |
| is_signed | input | 1 | Two's-complement compare for min/max |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand or broadcast scalar |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Registered packed result |
| illegal_op | output | 1 | Registered illegal opcode or size flag |

## Verification
Carry isolation is the hardest case to reach from the ports. A fault shows only when an element overflows exactly at a fracture boundary while its neighbour's value makes the leaked carry visible. Signed and unsigned compares differ only when an element's top bit is set. The stimulus therefore crosses operand patterns built from 0x00, 0x7F, 0x80, 0xFF and 0x01 in every byte with every opcode, size code and signedness. After that it runs a pseudo-random stream. Shift operands carry amounts at and above each element width.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SLL   = 4'd5,
    OP_SRL   = 4'd6,
    OP_MIN   = 4'd7,
    OP_MAX   = 4'd8,
    OP_MULLO = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } elem_size_e;

  localparam int SLICE_W = 8;

  // opcode recognised by the lane
  function automatic logic op_known(input logic [3:0] op);
    return op <= 4'd9;
  endfunction

  // slice k (in SLICE_W units) begins a new element for this size code
  function automatic logic slice_starts_elem(input logic [1:0] sz, input int k);
    case (sz)
      2'd0:    return 1'b1;
      2'd1:    return (k % 2) == 0;
      default: return k == 0;
    endcase
  endfunction

  // operation is served by the per-element unit
  function automatic logic op_is_elementwise(input logic [3:0] op);
    return (op >= 4'd5) && (op <= 4'd9);
  endfunction

endpackage

// File: rtl/simd_part_adder.sv
module simd_part_adder
  import simd_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]         a,
  input  logic [DW-1:0]         b,
  input  logic                  sub,
  input  logic [1:0]            esize,
  output logic [DW-1:0]         sum,
  output logic [DW/SLICE_W-1:0] slice_cin
);
  localparam int NS = DW / SLICE_W;

  logic [NS-1:0] slice_cout;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    logic [SLICE_W-1:0] bx;
    assign bx = b[k*SLICE_W +: SLICE_W] ^ {SLICE_W{sub}};

    if (k == 0) begin : g_first
      assign slice_cin[k] = sub;
    end else begin : g_next
      // a new element restarts with the subtract carry-in, else chain
      assign slice_cin[k] = slice_starts_elem(esize, k) ? sub : slice_cout[k-1];
    end

    if (k == NS - 1) begin : g_top
      assign sum[k*SLICE_W +: SLICE_W] = a[k*SLICE_W +: SLICE_W] + bx + {{(SLICE_W-1){1'b0}}, slice_cin[k]};
      assign slice_cout[k] = 1'b0;
    end else begin : g_mid
      logic [SLICE_W:0] s;
      assign s = {1'b0, a[k*SLICE_W +: SLICE_W]} + {1'b0, bx} + {{SLICE_W{1'b0}}, slice_cin[k]};
      assign sum[k*SLICE_W +: SLICE_W] = s[SLICE_W-1:0];
      assign slice_cout[k] = s[SLICE_W];
    end
  end
endmodule

// File: rtl/simd_elem.sv
module simd_elem
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         sgn,
  output logic [W-1:0] res
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] amt;
  logic           a_lt_b;
  logic [W-1:0]   prod;

  assign amt    = b[SHW-1:0];
  assign a_lt_b = sgn ? ($signed(a) < $signed(b)) : (a < b);
  assign prod   = a * b;

  always_comb begin
    case (op)
      OP_SLL:   res = a << amt;
      OP_SRL:   res = a >> amt;
      OP_MIN:   res = a_lt_b ? a : b;
      OP_MAX:   res = a_lt_b ? b : a;
      OP_MULLO: res = prod;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/simd_frac_unit.sv
module simd_frac_unit
  import simd_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    op,
  input  logic [1:0]    esize,
  input  logic          sgn,
  output logic [DW-1:0] res
);
  localparam int NSIZE = 3;

  logic [NSIZE-1:0][DW-1:0] res_by_size;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int W  = SLICE_W << s;
    localparam int NE = DW / W;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      simd_elem #(.W(W)) u_elem (
        .a  (a[e*W +: W]),
        .b  (b[e*W +: W]),
        .op (op),
        .sgn(sgn),
        .res(res_by_size[s][e*W +: W])
      );
    end
  end

  always_comb begin
    case (esize)
      2'd0:    res = res_by_size[0];
      2'd1:    res = res_by_size[1];
      2'd2:    res = res_by_size[2];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/simd_vec_alu.sv
module simd_vec_alu
  import simd_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [1:0]    esize,
  input  logic          is_signed,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          illegal_op
);
  localparam int NS = DW / SLICE_W;

  logic            is_sub;
  logic            bad_req;
  logic [DW-1:0]   add_sum;
  logic [NS-1:0]   add_cin;
  logic [DW-1:0]   frac_res;
  logic [DW-1:0]   next_res;

  assign is_sub  = (op == OP_SUB);
  assign bad_req = !op_known(op) || (esize == SZ_RSVD);

  simd_part_adder #(.DW(DW)) u_add (
    .a        (op_a),
    .b        (op_b),
    .sub      (is_sub),
    .esize    (esize),
    .sum      (add_sum),
    .slice_cin(add_cin)
  );

  simd_frac_unit #(.DW(DW)) u_frac (
    .a    (op_a),
    .b    (op_b),
    .op   (op),
    .esize(esize),
    .sgn  (is_signed),
    .res  (frac_res)
  );

  always_comb begin
    next_res = '0;
    if (!bad_req) begin
      case (op)
        OP_ADD, OP_SUB: next_res = add_sum;
        OP_AND:         next_res = op_a & op_b;
        OP_OR:          next_res = op_a | op_b;
        OP_XOR:         next_res = op_a ^ op_b;
        default:        next_res = op_is_elementwise(op) ? frac_res : '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      illegal_op <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= next_res;
        illegal_op <= bad_req;
      end
    end
  end

  // R2: valid tracks input valid with one cycle of latency
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2: outputs hold when no operation is presented
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal_op)));
  // R8: an illegal request leaves a zero result
  a_r8_zero_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (result == '0));
  // R3: in byte mode every slice restarts with the subtract carry-in
  a_r3_byte_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esize == SZ_BYTE) |-> (add_cin == {NS{op == OP_SUB}}));
  // R3: in halfword mode the upper half restarts independently
  a_r3_half_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esize == SZ_HALF) |-> (add_cin[NS/2] == (op == OP_SUB)));
  // R4: bitwise AND reaches the output one cycle later
  a_r4_and: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_AND && esize != SZ_RSVD) |=> (result == $past(op_a & op_b)));
endmodule

// File: tb/sim_simd_vec_alu.sv
module sim_simd_vec_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  esize;
  logic        is_signed;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] result;
  logic        illegal_op;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] last_res = '0;
  bit          last_ill = 1'b0;

  always #10 clk = ~clk;

  simd_vec_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
    .is_signed(is_signed), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
  );

  function automatic logic [31:0] model(input int opc, input int sz, input bit sg,
                                        input logic [31:0] a, input logic [31:0] b,
                                        output bit ill);
    int w;
    logic [63:0] m, msb, ae, be, r;
    logic [31:0] acc;
    bit lt;
    acc = '0;
    ill = (opc > 9) || (sz == 3);
    if (ill) return 32'h0;
    w   = 8 << sz;
    m   = (64'd1 << w) - 64'd1;
    msb = 64'd1 << (w - 1);
    for (int e = 0; e < 32 / w; e++) begin
      ae = ({32'h0, a} >> (e * w)) & m;
      be = ({32'h0, b} >> (e * w)) & m;
      lt = sg ? ((ae ^ msb) < (be ^ msb)) : (ae < be);
      case (opc)
        0: r = (ae + be) & m;
        1: r = (ae - be) & m;
        2: r = ae & be;
        3: r = ae | be;
        4: r = ae ^ be;
        5: r = (ae << (be % 64'(w))) & m;
        6: r = ae >> (be % 64'(w));
        7: r = lt ? ae : be;
        8: r = lt ? be : ae;
        default: r = (ae * be) & m;
      endcase
      acc = acc | 32'(r << (e * w));
    end
    return acc;
  endfunction

  function automatic string tag_of(input int opc, input int sz);
    if (opc > 9 || sz == 3) return "R8";
    case (opc)
      0, 1:    return "R3";
      2, 3, 4: return "R4";
      5, 6:    return "R5";
      7, 8:    return "R6";
      default: return "R7";
    endcase
  endfunction

  // starts and ends at a falling edge
  task automatic run_vec(input int opc, input int sz, input bit sg,
                         input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp_r;
    bit exp_i;
    exp_r = model(opc, sz, sg, a, b, exp_i);
    in_valid = 1'b1; op = 4'(opc); esize = 2'(sz); is_signed = sg;
    op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (out_valid !== 1'b1 || result !== exp_r || illegal_op !== exp_i) begin
      n_fail++;
      $display("FAIL %s (R2 latency) op=%0d sz=%0d sg=%0d a=%h b=%h got v=%b r=%h i=%b exp v=1 r=%h i=%b",
               tag_of(opc, sz), opc, sz, sg, a, b, out_valid, result, illegal_op, exp_r, exp_i);
    end
    last_res = exp_r;
    last_ill = exp_i;
  endtask

  // R2: idle cycle with changed inputs must not disturb the outputs
  task automatic idle_check(input logic [31:0] a, input logic [31:0] b);
    in_valid = 1'b0; op = 4'd0; esize = 2'd0; op_a = a; op_b = b;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== last_res || illegal_op !== last_ill) begin
      n_fail++;
      $display("FAIL R2 hold got v=%b r=%h i=%b exp v=0 r=%h i=%b",
               out_valid, result, illegal_op, last_res, last_ill);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] pat_a(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8080_8080;
      3: return 32'h7F7F_7F7F;
      4: return 32'h00FF_00FF;
      5: return 32'h1234_5678;
      6: return 32'hFF00_7F80;
      default: return 32'h0001_FFFE;
    endcase
  endfunction

  function automatic logic [31:0] pat_b(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0101_0101;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_7FFF;
      4: return 32'h0709_0F11;
      5: return 32'h1F20_2122;
      6: return 32'h7F80_0180;
      default: return 32'hFEDC_BA98;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got running exp finished");
      finish_up();
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; in_valid = 1'b1; op = 4'd0; esize = 2'd0; is_signed = 1'b0;
    op_a = 32'hFFFF_FFFF; op_b = 32'h1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || illegal_op !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset got v=%b r=%h i=%b exp v=0 r=0 i=0", out_valid, result, illegal_op);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 0; o < 16; o++)
      for (int s = 0; s < 4; s++)
        for (int g = 0; g < 2; g++)
          for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++)
              run_vec(o, s, bit'(g), pat_a(ia), pat_b(ib));
            idle_check(~pat_a(ia), pat_b(ia));
          end

    lf = 32'hACE1_1234;
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] ra, rb;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ra = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rb = lf ^ {lf[15:0], lf[31:16]};
      run_vec(int'(lf[3:0]) % 10, int'(lf[5:4]) % 3, lf[6], ra, rb);
    end
    idle_check(32'h5555_AAAA, 32'h3333_CCCC);

    done = 1'b1;
    finish_up();
  end
endmodule